// File: doc/BRIEF.md
# DRAM Access/Refresh Arbiter and Sequencer

This block sits between a processor bus and a two-bank dynamic memory array. It decides, clock by clock, whether the array is busy with a processor access or with a refresh. It then drives the row strobes, the column strobe, the ready line and the address multiplexer select in the right order. Refresh works by cycle stealing. A refresh that is pending when the array goes idle takes priority. An access that arrives while a refresh is running is held with ready low, and it is granted on the same edge on which the refresh finishes.

An access request is the falling edge of the latch enable while the select input is high. The bank input, sampled on that edge, picks one of the two row strobes. An active-low read or write strobe moves the sequencer to the column phase. The end of an access is either the release of that strobe or a new rising edge of the latch enable. A refresh request is a one-cycle pulse. The refresh drives both row strobes, lasts three clocks, or four when the wait strap is high, and emits a timer-reset pulse when it starts and a done pulse when it ends. Every output is registered, and all timing is counted in whole clock cycles.

Top module: `dram_arb_seq`

## Requirements
- R1: After reset both row strobes and the column strobe are high, ready is high, the mux select is row (2'b00), and the done and timer-reset pulses are low.
- R2: An access request in the idle state drives low the row strobe indexed by the bank input (bit 0 for bank 0, bit 1 for bank 1) on the same edge, with the mux select at row (2'b00).
- R3: While the row strobe of an access is low, sampling an active read or write strobe drives the column strobe low on that edge and sets the mux select to column (2'b01). This also applies when the strobe was already active before the access was granted.
- R4: The first edge on which the access strobes are sampled inactive after being active ends the access: all row strobes and the column strobe go high, and the mux select returns to row.
- R5: A rising edge of the latch enable during an access returns all row strobes and the column strobe high on that edge.
- R6: A refresh starts on the edge that accepts its request. Both row strobes go low, the mux select becomes refresh (2'b10), ready goes low, and the timer-reset output pulses high for exactly that one cycle.
- R7: A refresh keeps its strobes low for 3 cycles when the wait strap is low and for 4 cycles when it is high. On the ending edge the row strobes return high and the done output pulses high for one cycle.
- R8: An access requested during a refresh keeps ready low. It is granted, with its row strobe low, on the same edge on which the refresh ends.
- R9: When an access request and a refresh request reach the idle sequencer on the same edge, the refresh runs first and the access follows it.
- R10: Ready goes high on the edge that grants an access when the wait strap is low. When the wait strap is high, ready stays low on the granting edge and goes high one edge later.
- R11: A refresh requested during an access does not disturb the access. It starts on the edge after the access has returned to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Latch enable; its fall requests an access, its rise ends one |
| acc_sel | input | 1 | Select; an access is requested only when high |
| acc_bank | input | BANK_W | Bank index sampled with the request |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ref_req | input | 1 | One-cycle refresh request |
| wait_strap | input | 1 | Adds a ready wait state and lengthens refresh by one cycle |
| ras_n | output | NUM_BANKS | Active-low row strobes, one per bank |
| cas_n | output | 1 | Active-low column strobe |
| rdy | output | 1 | Ready to the processor |
| mux_sel | output | 2 | Address select: 00 row, 01 column, 10 refresh |
| ref_done | output | 1 | One-cycle pulse when a refresh ends |
| tmr_rst | output | 1 | One-cycle pulse when a refresh starts |

## Verification
Every output comes from a single register stage. A request or strobe change that is sampled on a rising edge therefore shows its result right after that same edge. The exceptions are the wait-state ready, which is due one edge later, and the refresh end, which is due 3 or 4 edges after the start. The bench changes its inputs on the falling edge and checks the outputs on the next falling edge. Each check therefore sees exactly one rising edge of effect. The refresh tasks count the edges explicitly, so a sequence that runs one cycle short or one cycle long is caught at the edge where it goes wrong.

// File: rtl/dras_pkg.sv
package dras_pkg;
    typedef enum logic [1:0] {
        MUX_ROW = 2'b00,
        MUX_COL = 2'b01,
        MUX_REF = 2'b10
    } mux_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACC_RAS,
        ST_ACC_CAS,
        ST_REF
    } seq_st_e;
endpackage

// File: rtl/dras_edge_hist.sv
module dras_edge_hist #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign prev_o = lvl_q;
endmodule

// File: rtl/dras_req_hold.sv
module dras_req_hold #(
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              ref_req_i,
    input  logic              acc_take_i,
    input  logic              ref_take_i,
    output logic              acc_pend_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              ref_pend_o
);
    typedef struct packed {
        logic              acc;
        logic [BANK_W-1:0] bank;
        logic              rfs;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        acc_pend_o = h_q.acc | acc_req_i;
        bank_o     = acc_req_i ? bank_i : h_q.bank;
        ref_pend_o = h_q.rfs | ref_req_i;
        h_d.acc    = acc_pend_o & ~acc_take_i;
        h_d.bank   = bank_o;
        h_d.rfs    = ref_pend_o & ~ref_take_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end
endmodule

// File: rtl/dras_seq.sv
module dras_seq
    import dras_pkg::*;
#(
    parameter int NUM_BANKS    = 2,
    parameter int REF_LEN_BASE = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_pend_i,
    input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
    input  logic                       ref_pend_i,
    input  logic                       ale_rise_i,
    input  logic                       stb_rise_i,
    input  logic                       stb_act_i,
    input  logic                       wait_i,
    output logic                       acc_take_o,
    output logic                       ref_take_o,
    output logic [NUM_BANKS-1:0]       ras_n_o,
    output logic                       cas_n_o,
    output logic                       rdy_o,
    output logic [1:0]                 mux_o,
    output logic                       ref_done_o,
    output logic                       tmr_rst_o
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int CNT_W  = $clog2(REF_LEN_BASE + 2);

    typedef struct packed {
        seq_st_e              st;
        logic [CNT_W-1:0]     cnt;
        logic [NUM_BANKS-1:0] ras_n;
        logic                 cas_n;
        logic                 rdy;
        mux_sel_e             mux;
        logic                 ref_done;
        logic                 tmr_rst;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] ref_last;

    function automatic logic [NUM_BANKS-1:0] row_mask(input logic [BANK_W-1:0] b);
        logic [NUM_BANKS-1:0] m;
        for (int i = 0; i < NUM_BANKS; i++) begin
            m[i] = (BANK_W'(i) == b) ? 1'b0 : 1'b1;
        end
        return m;
    endfunction

    always_comb begin
        ref_last   = wait_i ? CNT_W'(REF_LEN_BASE) : CNT_W'(REF_LEN_BASE - 1);
        s_d          = s_q;
        s_d.ref_done = 1'b0;
        s_d.tmr_rst  = 1'b0;
        acc_take_o   = 1'b0;
        ref_take_o   = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                s_d.rdy = 1'b1;
                if (ref_pend_i) begin
                    ref_take_o  = 1'b1;
                    s_d.st      = ST_REF;
                    s_d.cnt     = '0;
                    s_d.ras_n   = '0;
                    s_d.mux     = MUX_REF;
                    s_d.rdy     = 1'b0;
                    s_d.tmr_rst = 1'b1;
                end else if (acc_pend_i) begin
                    acc_take_o = 1'b1;
                    s_d.st     = ST_ACC_RAS;
                    s_d.ras_n  = row_mask(bank_i);
                    s_d.mux    = MUX_ROW;
                    s_d.rdy    = ~wait_i;
                end
            end
            ST_ACC_RAS: begin
                if (ale_rise_i || stb_rise_i) begin
                    s_d.st    = ST_IDLE;
                    s_d.ras_n = '1;
                    s_d.cas_n = 1'b1;
                    s_d.mux   = MUX_ROW;
                    s_d.rdy   = 1'b1;
                end else begin
                    s_d.rdy = 1'b1;
                    if (stb_act_i) begin
                        s_d.st    = ST_ACC_CAS;
                        s_d.cas_n = 1'b0;
                        s_d.mux   = MUX_COL;
                    end
                end
            end
            ST_ACC_CAS: begin
                s_d.rdy = 1'b1;
                if (ale_rise_i || stb_rise_i) begin
                    s_d.st    = ST_IDLE;
                    s_d.ras_n = '1;
                    s_d.cas_n = 1'b1;
                    s_d.mux   = MUX_ROW;
                end
            end
            ST_REF: begin
                if (s_q.cnt >= ref_last) begin
                    s_d.ref_done = 1'b1;
                    s_d.cnt      = '0;
                    if (acc_pend_i) begin
                        acc_take_o = 1'b1;
                        s_d.st     = ST_ACC_RAS;
                        s_d.ras_n  = row_mask(bank_i);
                        s_d.mux    = MUX_ROW;
                        s_d.rdy    = ~wait_i;
                    end else begin
                        s_d.st    = ST_IDLE;
                        s_d.ras_n = '1;
                        s_d.mux   = MUX_ROW;
                        s_d.rdy   = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    s_d.rdy = 1'b0;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st       <= ST_IDLE;
            s_q.cnt      <= '0;
            s_q.ras_n    <= '1;
            s_q.cas_n    <= 1'b1;
            s_q.rdy      <= 1'b1;
            s_q.mux      <= MUX_ROW;
            s_q.ref_done <= 1'b0;
            s_q.tmr_rst  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ras_n_o    = s_q.ras_n;
    assign cas_n_o    = s_q.cas_n;
    assign rdy_o      = s_q.rdy;
    assign mux_o      = s_q.mux;
    assign ref_done_o = s_q.ref_done;
    assign tmr_rst_o  = s_q.tmr_rst;
endmodule

// File: rtl/dram_arb_seq.sv
module dram_arb_seq #(
    parameter int NUM_BANKS    = 2,
    parameter int REF_LEN_BASE = 3,
    parameter int BANK_W       = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ale,
    input  logic                 acc_sel,
    input  logic [BANK_W-1:0]    acc_bank,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 ref_req,
    input  logic                 wait_strap,
    output logic [NUM_BANKS-1:0] ras_n,
    output logic                 cas_n,
    output logic                 rdy,
    output logic [1:0]           mux_sel,
    output logic                 ref_done,
    output logic                 tmr_rst
);
    logic [1:0]        hist_prev;
    logic              stb_act, ale_rise, ale_fall, stb_rise;
    logic              acc_req, acc_pend, ref_pend, acc_take, ref_take;
    logic [BANK_W-1:0] bank_sel;

    assign stb_act  = ~(rd_n & wr_n);
    assign ale_rise = ale & ~hist_prev[0];
    assign ale_fall = ~ale & hist_prev[0];
    assign stb_rise = ~stb_act & hist_prev[1];
    assign acc_req  = ale_fall & acc_sel;

    dras_edge_hist #(.W(2)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({stb_act, ale}),
        .prev_o (hist_prev)
    );

    dras_req_hold #(.BANK_W(BANK_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_req_i  (acc_req),
        .bank_i     (acc_bank),
        .ref_req_i  (ref_req),
        .acc_take_i (acc_take),
        .ref_take_i (ref_take),
        .acc_pend_o (acc_pend),
        .bank_o     (bank_sel),
        .ref_pend_o (ref_pend)
    );

    dras_seq #(.NUM_BANKS(NUM_BANKS), .REF_LEN_BASE(REF_LEN_BASE)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_pend_i (acc_pend),
        .bank_i     (bank_sel),
        .ref_pend_i (ref_pend),
        .ale_rise_i (ale_rise),
        .stb_rise_i (stb_rise),
        .stb_act_i  (stb_act),
        .wait_i     (wait_strap),
        .acc_take_o (acc_take),
        .ref_take_o (ref_take),
        .ras_n_o    (ras_n),
        .cas_n_o    (cas_n),
        .rdy_o      (rdy),
        .mux_o      (mux_sel),
        .ref_done_o (ref_done),
        .tmr_rst_o  (tmr_rst)
    );
endmodule

// File: rtl/dras_chk.sv
module dras_chk #(
    parameter int NUM_BANKS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ale,
    input logic                 rd_n,
    input logic                 wr_n,
    input logic [NUM_BANKS-1:0] ras_n,
    input logic                 cas_n,
    input logic                 rdy,
    input logic [1:0]           mux_sel,
    input logic                 ref_done,
    input logic                 tmr_rst
);
    a_r6_ref_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel == 2'b10) |-> (ras_n == '0 && !rdy));

    a_r6_tmr_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_rst |-> (mux_sel == 2'b10 && ras_n == '0));

    a_r3_cas_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> (mux_sel == 2'b01 && $countones(~ras_n) == 1));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |=> !ref_done);

    a_r4_stb_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && rd_n && wr_n && !($past(rd_n) && $past(wr_n)))
        |=> (cas_n && (&ras_n)));

    a_r5_ale_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !$past(ale) && mux_sel != 2'b10 && !(&ras_n))
        |=> (&ras_n));
endmodule

bind dram_arb_seq dras_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .rdy      (rdy),
    .mux_sel  (mux_sel),
    .ref_done (ref_done),
    .tmr_rst  (tmr_rst)
);

// File: tb/dram_arb_seq_tb_top.sv
module dram_arb_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ale = 1'b0, acc_sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic       ref_req = 1'b0, wait_strap = 1'b0;
    logic [0:0] acc_bank = 1'b0;
    logic [1:0] ras_n;
    logic       cas_n, rdy, ref_done, tmr_rst;
    logic [1:0] mux_sel;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    dram_arb_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ale(ale), .acc_sel(acc_sel), .acc_bank(acc_bank),
        .rd_n(rd_n), .wr_n(wr_n), .ref_req(ref_req), .wait_strap(wait_strap),
        .ras_n(ras_n), .cas_n(cas_n), .rdy(rdy), .mux_sel(mux_sel),
        .ref_done(ref_done), .tmr_rst(tmr_rst)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // {ras_n, cas_n, rdy, mux_sel, ref_done, tmr_rst}
    function automatic logic [7:0] snap();
        return {ras_n, cas_n, rdy, mux_sel, ref_done, tmr_rst};
    endfunction

    task automatic req_acc(input logic b);
        ale = 1'b1; cyc();
        ale = 1'b0; acc_sel = 1'b1; acc_bank = b; cyc();
        acc_sel = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset", snap(), {2'b11, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0});
    endtask

    task automatic t_access(input logic b, input logic w);
        wait_strap = w;
        req_acc(b);
        chk(w ? "R10 grant rdy held" : "R2 grant", snap(),
            {(b ? 2'b01 : 2'b10), 1'b1, ~w, 2'b00, 1'b0, 1'b0});
        cyc();
        chk("R10 rdy one edge later", {7'd0, rdy}, 8'd1);
        rd_n = 1'b0; cyc();
        chk("R3 column phase", snap(), {(b ? 2'b01 : 2'b10), 1'b0, 1'b1, 2'b01, 1'b0, 1'b0});
        rd_n = 1'b1; cyc();
        chk("R4 strobe release", snap(), {2'b11, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0});
        wait_strap = 1'b0;
    endtask

    task automatic t_ale_end();
        req_acc(1'b0);
        cyc();
        ale = 1'b1; cyc();
        chk("R5 ale rise release", snap(), {2'b11, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0});
        ale = 1'b0; cyc();
        chk("R5 no new access", {6'd0, ras_n}, 8'h03);
    endtask

    task automatic t_refresh(input logic w);
        int len;
        len = w ? 4 : 3;
        wait_strap = w;
        ref_req = 1'b1; cyc(); ref_req = 1'b0;
        chk("R6 refresh start", snap(), {2'b00, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1});
        for (int k = 1; k < len; k++) begin
            cyc();
            chk("R7 refresh held", snap(), {2'b00, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0});
        end
        cyc();
        chk("R7 refresh end", snap(), {2'b11, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0});
        cyc();
        chk("R7 done single cycle", {7'd0, ref_done}, 8'd0);
        wait_strap = 1'b0;
    endtask

    task automatic t_collide();
        ref_req = 1'b1; cyc(); ref_req = 1'b0;
        ale = 1'b1; cyc();
        ale = 1'b0; acc_sel = 1'b1; acc_bank = 1'b1; cyc();
        acc_sel = 1'b0;
        chk("R8 access held off", snap(), {2'b00, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0});
        rd_n = 1'b0; cyc();
        chk("R8 grant at refresh end", snap(), {2'b01, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0});
        cyc();
        chk("R3 column after early strobe", {7'd0, cas_n}, 8'd0);
        rd_n = 1'b1; cyc();
        chk("R4 release after grant", {5'd0, ras_n, cas_n}, 8'h07);
    endtask

    task automatic t_simul();
        ale = 1'b1; cyc();
        ale = 1'b0; acc_sel = 1'b1; acc_bank = 1'b0; ref_req = 1'b1; cyc();
        acc_sel = 1'b0; ref_req = 1'b0;
        chk("R9 refresh wins", snap(), {2'b00, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1});
        cyc(); cyc(); cyc();
        chk("R9 access follows", snap(), {2'b10, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0});
        wr_n = 1'b0; cyc();
        wr_n = 1'b1; cyc();
        chk("R9 access closed", {5'd0, ras_n, cas_n}, 8'h07);
    endtask

    task automatic t_ref_in_acc();
        req_acc(1'b1);
        wr_n = 1'b0; cyc();
        ref_req = 1'b1; cyc(); ref_req = 1'b0;
        chk("R11 access undisturbed", snap(), {2'b01, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0});
        wr_n = 1'b1; cyc();
        chk("R11 access ends first", snap(), {2'b11, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0});
        cyc();
        chk("R11 refresh follows", snap(), {2'b00, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1});
        cyc(); cyc(); cyc();
        chk("R11 refresh done", {6'd0, ref_done, ras_n[0]}, 8'h03);
        cyc();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_access(1'b0, 1'b0);
        t_access(1'b1, 1'b0);
        t_access(1'b1, 1'b1);
        t_ale_end();
        t_refresh(1'b0);
        t_refresh(1'b1);
        t_collide();
        t_simul();
        t_ref_in_acc();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule